// File: doc/BRIEF.md
# Acquisition Trigger Sequencer with Supply-Settling Delay

This block runs the acquisition cycle of a switched-capacitor waveform sampler. While the host holds its run bit high, the block keeps the sampling wave running with writing enabled and waits for a trigger. The trigger can be a rising edge on a hardware line or a one-cycle software pulse. When a trigger arrives, the block stops writing into the cell array. It then waits a programmable number of clock cycles so that the analog supply can recover from the load step. After the wait it fires a one-cycle start request to a separate ADC readout engine and waits for that engine to report completion. Last, it restores writing and re-arms.

A keep-wave option lets the sampling wave run through the trigger, so that only writing stops. The settling length is a port value sampled at the start of each wait. A host that wants a wait of about 120 us supplies the matching cycle count, for example 15000 at 125 MHz. A count of zero removes the wait. Every pin is a plain control or status level or pulse. No data passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `acq_seq_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wave_en`, `write_en`, `rdout_start` and `busy` are all 0.
- R2: When `run_en` is high in the idle state, from the next cycle on `wave_en` and `write_en` are 1 and `busy` is 0 (armed). Whenever `busy` is 0, `wave_en` equals `write_en`.
- R3: In the armed state, a trigger is `sw_trig` high at a clock edge, or `hw_trig` high at an edge when it was low at the previous edge. In the cycle after that edge, `write_en` is 0 and `busy` is 1. `wave_en` is 1 if `keep_wave` was high at the trigger edge, and 0 otherwise.
- R4: Let N be `settle_cycles` sampled one edge after the trigger edge t. Then `rdout_start` is high for exactly one cycle: the cycle after edge t+N+1. With N=0 this is the cycle after edge t+1.
- R5: From the trigger until `rdout_done` is accepted, `write_en` stays 0 and `wave_en` keeps the value given by R3.
- R6: `rdout_done` high at an edge while the block waits for readout gives one cycle with `wave_en`=1, `write_en`=1 and `busy`=1. In the following cycle `busy` is 0, with the block armed again.
- R7: A trigger while busy or idle is ignored. An `rdout_done` before `rdout_start` has been issued is ignored. Neither one changes the outputs or the timing of `rdout_start`.
- R8: A `hw_trig` held high causes only one trigger. A new trigger needs a fresh low-to-high transition.
- R9: `run_en` low at any edge forces the idle state: in the next cycle `wave_en`, `write_en`, `rdout_start` and `busy` are 0.
- R10: Changes to `settle_cycles` after the wait has loaded it do not change the wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Host run bit; low forces idle |
| hw_trig | input | 1 | Hardware trigger, rising-edge sensitive |
| sw_trig | input | 1 | Software trigger pulse |
| keep_wave | input | 1 | Keep the sampling wave running through a trigger |
| settle_cycles | input | CNT_W | Supply-settling wait in clock cycles, 0 skips it |
| rdout_done | input | 1 | Readout engine finished |
| wave_en | output | 1 | Sampling wave enable to the chip |
| write_en | output | 1 | Cell write enable to the chip |
| rdout_start | output | 1 | One-cycle readout request |
| busy | output | 1 | Acquisition cycle in progress |

## Verification
The hardest states to reach are the ones where a stray event arrives in the middle of the settling wait. These are a second software trigger, a new hardware edge, an early completion from the readout engine, or a change of the wait count. Such events can disturb the counter without leaving any trace on `write_en`. The stimulus therefore counts cycles from the trigger and injects these events at chosen offsets inside the wait. It then measures the exact cycle in which `rdout_start` appears and compares it with the count that was loaded. A held hardware trigger is carried across the whole cycle, through the return to the armed state, to show that no second acquisition starts.

// File: rtl/acq_seq_pkg.sv
`timescale 1ns/1ps
package acq_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_ARMED  = 3'd1,
    S_STOP   = 3'd2,
    S_SETTLE = 3'd3,
    S_LAUNCH = 3'd4,
    S_READ   = 3'd5,
    S_DONE   = 3'd6
  } seq_state_e;
endpackage

// File: rtl/acq_trig_qual.sv
`timescale 1ns/1ps
// Qualifies triggers: hardware line on rising edge, software pulse as level,
// both accepted only while armed.
module acq_trig_qual (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic hw_trig,
  input  logic sw_trig,
  output logic trig_hit
);
  logic hw_q;

  always_ff @(posedge clk) begin
    if (!rst_n) hw_q <= 1'b0;
    else        hw_q <= hw_trig;
  end

  assign trig_hit = armed & (sw_trig | (hw_trig & ~hw_q));
endmodule

// File: rtl/acq_settle_timer.sv
`timescale 1ns/1ps
// Down-counter for the supply-settling wait; expire marks the last wait cycle.
module acq_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         cnt <= '0;
    else if (load)                      cnt <= load_val;
    else if (run && cnt != '0)          cnt <= cnt - ONE;
  end

  assign expire = run && (cnt == ONE);
endmodule

// File: rtl/acq_seq_fsm.sv
`timescale 1ns/1ps
module acq_seq_fsm
  import acq_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             trig_hit,
  input  logic             keep_wave,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             settle_expire,
  input  logic             rdout_done,
  output seq_state_e       state,
  output logic             kept,
  output logic             settle_load
);
  seq_state_e nxt;
  logic       skip_wait;

  assign skip_wait   = (settle_cycles == '0);
  assign settle_load = (state == S_STOP);

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:   nxt = S_ARMED;
      S_ARMED:  if (trig_hit) nxt = S_STOP;
      S_STOP:   nxt = skip_wait ? S_LAUNCH : S_SETTLE;
      S_SETTLE: if (settle_expire) nxt = S_LAUNCH;
      S_LAUNCH: nxt = S_READ;
      S_READ:   if (rdout_done) nxt = S_DONE;
      S_DONE:   nxt = S_ARMED;
      default:  nxt = S_IDLE;
    endcase
    if (!run_en) nxt = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      kept  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == S_ARMED && trig_hit) kept <= keep_wave;
    end
  end
endmodule

// File: rtl/acq_out_dec.sv
`timescale 1ns/1ps
module acq_out_dec
  import acq_seq_pkg::*;
(
  input  seq_state_e state,
  input  logic       kept,
  output logic       wave_en,
  output logic       write_en,
  output logic       rdout_start,
  output logic       busy
);
  always_comb begin
    wave_en     = 1'b0;
    write_en    = 1'b0;
    rdout_start = 1'b0;
    busy        = 1'b0;
    unique case (state)
      S_IDLE:  ;
      S_ARMED: begin wave_en = 1'b1; write_en = 1'b1; end
      S_STOP, S_SETTLE, S_READ: begin
        wave_en = kept; busy = 1'b1;
      end
      S_LAUNCH: begin wave_en = kept; busy = 1'b1; rdout_start = 1'b1; end
      S_DONE:  begin wave_en = 1'b1; write_en = 1'b1; busy = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/acq_seq_top.sv
`timescale 1ns/1ps
module acq_seq_top
  import acq_seq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             hw_trig,
  input  logic             sw_trig,
  input  logic             keep_wave,
  input  logic [CNT_W-1:0] settle_cycles,
  input  logic             rdout_done,
  output logic             wave_en,
  output logic             write_en,
  output logic             rdout_start,
  output logic             busy
);
  seq_state_e state;
  logic       kept, trig_hit, settle_load, settle_expire;

  acq_trig_qual u_trig (
    .clk(clk), .rst_n(rst_n), .armed(state == S_ARMED),
    .hw_trig(hw_trig), .sw_trig(sw_trig), .trig_hit(trig_hit)
  );

  acq_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(settle_load), .load_val(settle_cycles),
    .run(state == S_SETTLE), .expire(settle_expire)
  );

  acq_seq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .trig_hit(trig_hit),
    .keep_wave(keep_wave), .settle_cycles(settle_cycles),
    .settle_expire(settle_expire), .rdout_done(rdout_done),
    .state(state), .kept(kept), .settle_load(settle_load)
  );

  acq_out_dec u_dec (
    .state(state), .kept(kept), .wave_en(wave_en), .write_en(write_en),
    .rdout_start(rdout_start), .busy(busy)
  );
endmodule

// File: rtl/acq_seq_chk.sv
`timescale 1ns/1ps
module acq_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic run_en,
  input logic wave_en,
  input logic write_en,
  input logic rdout_start,
  input logic busy
);
  p_armed_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wave_en == write_en));

  p_trig_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !write_en);

  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdout_start |=> !rdout_start);

  p_no_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdout_start |-> (busy && !write_en));

  p_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $rose(write_en)) |=> !busy);

  p_force_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> (!wave_en && !write_en && !busy && !rdout_start));
endmodule

bind acq_seq_top acq_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .wave_en(wave_en),
  .write_en(write_en), .rdout_start(rdout_start), .busy(busy)
);

// File: tb/tb_acq_seq_top.sv
`timescale 1ns/1ps
module tb_acq_seq_top;
  localparam int CNT_W = 16;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run_en = 1'b0, hw_trig = 1'b0, sw_trig = 1'b0, keep_wave = 1'b0;
  logic rd_done = 1'b0;
  logic [CNT_W-1:0] settle = '0;
  logic wave_en, write_en, rdout_start, busy;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  acq_seq_top #(.CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .hw_trig(hw_trig),
    .sw_trig(sw_trig), .keep_wave(keep_wave), .settle_cycles(settle),
    .rdout_done(rd_done), .wave_en(wave_en), .write_en(write_en),
    .rdout_start(rdout_start), .busy(busy)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // outputs packed {wave,write,start,busy}
  function automatic int outs();
    return {28'd0, wave_en, write_en, rdout_start, busy};
  endfunction

  task automatic arm();
    run_en = 1'b1; step();
    chk("R2 armed outputs", outs(), 4'b1100);
  endtask

  task automatic sw_pulse();
    sw_trig = 1'b1; step(); sw_trig = 1'b0;
  endtask

  // steps from now until rdout_start, checking write_en stays low
  task automatic wait_start(output int k);
    k = 0;
    while (!rdout_start && k < 500) begin
      if (write_en) chk("R5 write low in wait", write_en, 0);
      step(); k++;
    end
  endtask

  task automatic finish_rd();
    rd_done = 1'b1; step(); rd_done = 1'b0; step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; repeat (3) step();
    chk("R1 outputs in reset", outs(), 0);
    rst_n = 1'b1; step();
    chk("R1 outputs after reset", outs(), 0);
  endtask

  task automatic t_basic();
    int k;
    settle = 16'd3; keep_wave = 1'b0;
    arm();
    sw_pulse();
    chk("R3 after trigger", outs(), 4'b0001);
    wait_start(k);
    chk("R4 start delay N=3", k, 4);
    step();
    chk("R4 start one cycle", rdout_start, 0);
    chk("R5 during readout", outs(), 4'b0001);
    repeat (3) step();
    chk("R5 still waiting", outs(), 4'b0001);
    rd_done = 1'b1; step(); rd_done = 1'b0;
    chk("R6 done cycle", outs(), 4'b1101);
    step();
    chk("R6 rearmed", outs(), 4'b1100);
  endtask

  task automatic t_zero();
    int k;
    settle = 16'd0;
    sw_pulse();
    wait_start(k);
    chk("R4 zero wait", k, 1);
    step(); finish_rd();
    chk("R6 rearmed after zero", outs(), 4'b1100);
  endtask

  task automatic t_keep();
    int k;
    settle = 16'd2; keep_wave = 1'b1;
    sw_pulse();
    keep_wave = 1'b0;
    chk("R3 keep wave", outs(), 4'b1001);
    wait_start(k);
    chk("R4 delay N=2", k, 3);
    step();
    chk("R5 wave kept in readout", outs(), 4'b1001);
    finish_rd();
  endtask

  task automatic t_ignore();
    int k;
    run_en = 1'b0; step();
    sw_pulse();
    chk("R7 idle trigger ignored", outs(), 0);
    arm();
    settle = 16'd5;
    sw_pulse();
    step(); step();
    sw_trig = 1'b1; hw_trig = 1'b1; rd_done = 1'b1; step();
    sw_trig = 1'b0; hw_trig = 1'b0; rd_done = 1'b0;
    chk("R7 busy during stray events", outs(), 4'b0001);
    wait_start(k);
    chk("R7 start timing unchanged", k, 3);
    step(); step();
    chk("R7 still waiting for done", outs(), 4'b0001);
    finish_rd();
    repeat (3) step();
    chk("R7 no queued trigger", outs(), 4'b1100);
  endtask

  task automatic t_hw_hold();
    int k;
    settle = 16'd1;
    hw_trig = 1'b1; step();
    chk("R3 hw edge triggers", outs(), 4'b0001);
    wait_start(k);
    chk("R4 delay N=1", k, 2);
    step(); finish_rd();
    repeat (3) step();
    chk("R8 held hw no retrigger", outs(), 4'b1100);
    hw_trig = 1'b0; step();
    hw_trig = 1'b1; step();
    chk("R8 fresh edge triggers", busy, 1);
    hw_trig = 1'b0;
    wait_start(k); step(); finish_rd();
  endtask

  task automatic t_abort();
    int k;
    settle = 16'd2;
    sw_pulse(); wait_start(k); step();
    run_en = 1'b0; step();
    chk("R9 forced idle", outs(), 0);
    rd_done = 1'b1; step(); rd_done = 1'b0;
    chk("R9 stays idle", outs(), 0);
    arm();
  endtask

  task automatic t_change();
    int k;
    settle = 16'd4;
    sw_pulse();
    step();
    settle = 16'd1;
    wait_start(k);
    chk("R10 loaded count kept", k, 4);
    step(); finish_rd();
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_basic();
    t_zero();
    t_keep();
    t_ignore();
    t_hw_hold();
    t_abort();
    t_change();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule